// File: doc/BRIEF.md
# USB Endpoint Transaction Status Tracker

This block follows transactions on a full-speed USB device port with eight endpoints. A packet engine upstream hands it events that are already decoded: tokens with their kind and endpoint number, data packets with their data PID and byte length, handshakes, receive timeouts and bus reset. Firmware arms each endpoint for one direction and sets a byte count. The tracker then records how the next transaction on that endpoint ends. It keeps a status word per endpoint, a count-result field holding the bytes left over, and a transaction-done interrupt flag per endpoint, with a separate flag for bus reset.

Each endpoint runs its own small state machine with four named states. `EP_IDLE` means not armed. `EP_ARMED` waits for a token. `EP_XFER` waits for the data packet. `EP_HSK` waits for the handshake. The transitions are as follows:

- arm write: any state to `EP_ARMED`; disarm write: any state to `EP_IDLE`.
- token in the armed direction: `EP_ARMED` to `EP_XFER`.
- token in the wrong direction: `EP_ARMED` to `EP_IDLE`, recording an exception.
- data packet: `EP_XFER` to `EP_HSK`. On an isochronous endpoint it goes straight to `EP_IDLE`.
- ACK: `EP_HSK` to `EP_IDLE`.
- STALL or timeout: `EP_XFER` or `EP_HSK` to `EP_IDLE`.
- NAK: `EP_XFER` or `EP_HSK` back to `EP_ARMED`.
- bus reset: any state to `EP_IDLE`.

The CPU reaches the registers through a plain address/data port. Reads are combinational. Writes take effect on the clock edge.

Top module: `usb_ep_txn_tracker`

## Requirements
- R1: After reset every endpoint reads as not armed, with status, count and count result zero, and the interrupt enable and flag registers read zero. Register map: endpoint e has control at address 4e (bit0 armed, bit1 direction IN, bit2 isochronous), count at 4e+1 (10 bits), status at 4e+2 and count result at 4e+3. Interrupt enable is at 0x20 and interrupt flags at 0x21. Flag bit e belongs to endpoint e and bit 8 to bus reset.
- R2: Writing control with bit0 set arms the endpoint and clears its status. The control readback shows armed, direction and isochronous. Writing bit0 as 0 disarms it.
- R3: An IN token (kind 1) on an endpoint armed for OUT sets status bit4 (IN exception). An OUT token (kind 0) or SETUP token (kind 2) on an endpoint armed for IN sets status bit5 (OUT exception). Either one ends the transaction with a done event and disarms the endpoint.
- R4: On a non-isochronous endpoint, a data packet followed by an ACK handshake (kind 0) sets status bit0, raises done and disarms the endpoint. The count result becomes the armed count minus the data length.
- R5: A STALL handshake (kind 2) after the token or after the data sets status bit1, raises done and disarms the endpoint.
- R6: A timeout after the token or after the data sets status bit2, raises done and disarms the endpoint.
- R7: Status bit3 holds the PID of the last data packet received on an OUT-armed endpoint (1 = DATA1). Status bit6 is set when the transaction began with a SETUP token.
- R8: On an isochronous endpoint the data packet alone completes the transaction. It sets status bit0 (ACK meaning success), raises done and updates the count result.
- R9: A NAK handshake (kind 1) returns the endpoint to waiting for a token. It raises no done, leaves the endpoint armed and leaves the status unchanged.
- R10: An endpoint that is not armed ignores tokens, data, handshakes and timeouts. Its status and count result do not change.
- R11: An interrupt flag is set only when its enable bit is 1. Writing 1 to a flag bit clears it. A set in the same cycle as a clear wins.
- R12: Bus reset sets flag bit8 when enabled, clears every endpoint's status and disarms every endpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token event strobe |
| tok_kind | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP |
| tok_ep | input | 3 | Endpoint number of the token |
| dat_valid | input | 1 | Data packet event strobe, for the endpoint of the last token |
| dat_odd | input | 1 | Data PID, 1 = DATA1 |
| dat_len | input | 10 | Data packet length in bytes |
| hsk_valid | input | 1 | Handshake event strobe |
| hsk_kind | input | 2 | Handshake: 0 ACK, 1 NAK, 2 STALL |
| tmo_valid | input | 1 | Timeout event strobe |
| bus_rst | input | 1 | USB bus reset detected |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 6 | CPU register address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data for cpu_addr |

## Verification
The main function is tried with several transaction shapes:

- OUT data followed by ACK, with an odd PID.
- IN data refused by NAK and then retried.
- IN data ending in a timeout.
- IN with an immediate STALL.
- An isochronous OUT with no handshake.
- A SETUP exchange.

Between them these show apart the ACK, stall, timeout and sequence bits and the count-result arithmetic, and they show whether the isochronous path skips the handshake wait. Wrong-direction tokens in both senses check that the two exception bits are not swapped. Events sent to an unarmed endpoint, a masked flag, a flag clear that coincides with a set, and a bus reset in the middle of a transaction check the masking, the priority and the clearing rules.

// File: rtl/ep_trk_pkg.sv
package ep_trk_pkg;

    typedef enum logic [1:0] {
        EP_IDLE  = 2'd0,
        EP_ARMED = 2'd1,
        EP_XFER  = 2'd2,
        EP_HSK   = 2'd3
    } ep_state_e;

    typedef enum logic [1:0] {
        TK_OUT   = 2'd0,
        TK_IN    = 2'd1,
        TK_SETUP = 2'd2,
        TK_RSVD  = 2'd3
    } tok_kind_e;

    typedef enum logic [1:0] {
        HK_ACK   = 2'd0,
        HK_NAK   = 2'd1,
        HK_STALL = 2'd2,
        HK_RSVD  = 2'd3
    } hsk_kind_e;

    // status word, bit 6 down to bit 0
    typedef struct packed {
        logic setup;
        logic out_exc;
        logic in_exc;
        logic seq;
        logic tmo;
        logic stall;
        logic ack;
    } ep_stat_t;

    localparam int STAT_W = $bits(ep_stat_t);

endpackage

// File: rtl/ep_irq_bank.sv
module ep_irq_bank #(
    parameter int N_FLAG = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_FLAG-1:0] set_vec,
    input  logic              en_we,
    input  logic [N_FLAG-1:0] en_wdata,
    input  logic              clr_we,
    input  logic [N_FLAG-1:0] clr_wdata,
    output logic [N_FLAG-1:0] enables,
    output logic [N_FLAG-1:0] flags
);

    logic [N_FLAG-1:0] clr_mask;
    logic [N_FLAG-1:0] set_mask;

    always_comb begin
        clr_mask = clr_we ? clr_wdata : '0;
        set_mask = set_vec & enables;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enables <= '0;
        end else if (en_we) begin
            enables <= en_wdata;
        end
    end

    // a set event outranks a write-one-to-clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_mask) | set_mask;
        end
    end

    p_set_beats_clear_r11 : assert property (
        @(posedge clk) disable iff (!rst_n)
        (|(set_vec & enables)) |=> ((flags & $past(set_vec & enables)) == $past(set_vec & enables))
    ) else $error("enabled set event lost");

    p_masked_no_rise_r11 : assert property (
        @(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(enables)) == '0)
    ) else $error("flag rose while disabled");

    p_clear_works_r11 : assert property (
        @(posedge clk) disable iff (!rst_n)
        (clr_we && ((clr_wdata & set_vec & enables) == '0)) |=> ((flags & $past(clr_wdata)) == '0)
    ) else $error("flag not cleared");

endmodule

// File: rtl/ep_txn_fsm.sv
module ep_txn_fsm
    import ep_trk_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             cfg_we,
    input  logic             cfg_arm,
    input  logic             cfg_dir_in,
    input  logic             cfg_iso,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             tok_hit,
    input  tok_kind_e        tok_kind,
    input  logic             evt_sel,
    input  logic             dat_valid,
    input  logic             dat_odd,
    input  logic [CNT_W-1:0] dat_len,
    input  logic             hsk_valid,
    input  hsk_kind_e        hsk_kind,
    input  logic             tmo_valid,
    output logic             armed,
    output logic             dir_in,
    output logic             iso,
    output logic [CNT_W-1:0] count,
    output ep_stat_t         status,
    output logic [CNT_W-1:0] count_res,
    output logic             done
);

    ep_state_e        state_q, state_d;
    ep_stat_t         set_bits;
    logic             seq_wr;
    logic             seq_val;
    logic             len_take;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] len_eff;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and per-cycle outputs
    always_comb begin
        state_d  = state_q;
        done     = 1'b0;
        set_bits = '0;
        seq_wr   = 1'b0;
        seq_val  = 1'b0;
        len_take = 1'b0;
        unique case (state_q)
            EP_IDLE: begin
                state_d = EP_IDLE;
            end
            EP_ARMED: begin
                if (tok_hit) begin
                    if (tok_kind == TK_IN && !dir_in) begin
                        set_bits.in_exc = 1'b1;
                        done            = 1'b1;
                        state_d         = EP_IDLE;
                    end else if (tok_kind != TK_IN && dir_in) begin
                        set_bits.out_exc = 1'b1;
                        done             = 1'b1;
                        state_d          = EP_IDLE;
                    end else begin
                        set_bits.setup = (tok_kind == TK_SETUP);
                        state_d        = EP_XFER;
                    end
                end
            end
            EP_XFER: begin
                if (evt_sel) begin
                    if (dat_valid) begin
                        len_take = 1'b1;
                        seq_wr   = !dir_in;
                        seq_val  = dat_odd;
                        if (iso) begin
                            set_bits.ack = 1'b1;
                            done         = 1'b1;
                            state_d      = EP_IDLE;
                        end else begin
                            state_d = EP_HSK;
                        end
                    end else if (hsk_valid && hsk_kind == HK_STALL) begin
                        set_bits.stall = 1'b1;
                        done           = 1'b1;
                        state_d        = EP_IDLE;
                    end else if (hsk_valid && hsk_kind == HK_NAK) begin
                        state_d = EP_ARMED;
                    end else if (tmo_valid) begin
                        set_bits.tmo = 1'b1;
                        done         = 1'b1;
                        state_d      = EP_IDLE;
                    end
                end
            end
            EP_HSK: begin
                if (evt_sel) begin
                    if (hsk_valid && hsk_kind == HK_ACK) begin
                        set_bits.ack = 1'b1;
                        done         = 1'b1;
                        state_d      = EP_IDLE;
                    end else if (hsk_valid && hsk_kind == HK_STALL) begin
                        set_bits.stall = 1'b1;
                        done           = 1'b1;
                        state_d        = EP_IDLE;
                    end else if (hsk_valid && hsk_kind == HK_NAK) begin
                        state_d = EP_ARMED;
                    end else if (tmo_valid) begin
                        set_bits.tmo = 1'b1;
                        done         = 1'b1;
                        state_d      = EP_IDLE;
                    end
                end
            end
            default: begin
                state_d = EP_IDLE;
            end
        endcase
        if (cfg_we) begin
            state_d  = cfg_arm ? EP_ARMED : EP_IDLE;
            done     = 1'b0;
            set_bits = '0;
            seq_wr   = 1'b0;
            len_take = 1'b0;
        end
        if (bus_reset) begin
            state_d  = EP_IDLE;
            done     = 1'b0;
            set_bits = '0;
            seq_wr   = 1'b0;
            len_take = 1'b0;
        end
    end

    assign armed   = (state_q != EP_IDLE);
    assign len_eff = len_take ? dat_len : len_q;

    // configuration held by the CPU
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_in <= 1'b0;
            iso    <= 1'b0;
            count  <= '0;
        end else begin
            if (cfg_we) begin
                dir_in <= cfg_dir_in;
                iso    <= cfg_iso;
            end
            if (cnt_we) begin
                count <= cnt_wdata;
            end
        end
    end

    // transaction record
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            status    <= '0;
            len_q     <= '0;
            count_res <= '0;
        end else if (cfg_we && cfg_arm) begin
            status <= '0;
            len_q  <= '0;
        end else begin
            status <= status | set_bits;
            if (seq_wr) begin
                status.seq <= seq_val;
            end
            if (len_take) begin
                len_q <= dat_len;
            end
            if (done) begin
                count_res <= count - len_eff;
            end
        end
    end

    p_idle_ignores_r10 : assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == EP_IDLE && !cfg_we && !bus_reset)
            |=> ($stable(status) && $stable(count_res) && state_q == EP_IDLE)
    ) else $error("idle endpoint changed");

    p_in_exception_r3 : assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == EP_ARMED && tok_hit && tok_kind == TK_IN && !dir_in && !cfg_we && !bus_reset)
            |=> (status.in_exc && !armed)
    ) else $error("IN exception not recorded");

    p_bus_reset_clears_r12 : assert property (
        @(posedge clk) disable iff (!rst_n)
        bus_reset |=> (status == '0 && !armed)
    ) else $error("bus reset did not clear endpoint");

    p_nak_rearms_r9 : assert property (
        @(posedge clk) disable iff (!rst_n)
        ((state_q == EP_HSK || state_q == EP_XFER) && evt_sel && hsk_valid && hsk_kind == HK_NAK
            && !dat_valid && !cfg_we && !bus_reset)
            |=> (state_q == EP_ARMED && $stable(status))
    ) else $error("NAK did not re-arm");

endmodule

// File: rtl/usb_ep_txn_tracker.sv
module usb_ep_txn_tracker
    import ep_trk_pkg::*;
#(
    parameter int N_EP   = 8,
    parameter int CNT_W  = 10,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tok_valid,
    input  logic [1:0]              tok_kind,
    input  logic [$clog2(N_EP)-1:0] tok_ep,
    input  logic                    dat_valid,
    input  logic                    dat_odd,
    input  logic [CNT_W-1:0]        dat_len,
    input  logic                    hsk_valid,
    input  logic [1:0]              hsk_kind,
    input  logic                    tmo_valid,
    input  logic                    bus_rst,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic [DATA_W-1:0]       cpu_rdata
);

    localparam int EP_W      = $clog2(N_EP);
    localparam int N_FLAG    = N_EP + 1;
    localparam int IRQ_EN_A  = 1 << (ADDR_W - 1);
    localparam int IRQ_FLG_A = IRQ_EN_A + 1;

    logic [EP_W-1:0]   cur_ep;
    logic              ep_space;
    logic [EP_W-1:0]   a_ep;
    logic [1:0]        a_reg;
    logic [N_EP-1:0]   ep_armed, ep_dir, ep_iso, ep_done;
    logic [CNT_W-1:0]  ep_count [N_EP];
    logic [CNT_W-1:0]  ep_res   [N_EP];
    ep_stat_t          ep_stat  [N_EP];
    logic [N_FLAG-1:0] irq_en, irq_flags;
    logic              unused_wdata;

    assign ep_space     = !cpu_addr[ADDR_W-1];
    assign a_ep         = cpu_addr[EP_W+1:2];
    assign a_reg        = cpu_addr[1:0];
    assign unused_wdata = ^cpu_wdata[DATA_W-1:CNT_W];

    // endpoint that data, handshake and timeout events refer to
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ep <= '0;
        end else if (tok_valid) begin
            cur_ep <= tok_ep;
        end
    end

    for (genvar e = 0; e < N_EP; e++) begin : g_ep
        logic hit_cfg, hit_cnt;
        assign hit_cfg = cpu_we && ep_space && a_ep == EP_W'(e) && a_reg == 2'd0;
        assign hit_cnt = cpu_we && ep_space && a_ep == EP_W'(e) && a_reg == 2'd1;

        ep_txn_fsm #(.CNT_W(CNT_W)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_reset (bus_rst),
            .cfg_we    (hit_cfg),
            .cfg_arm   (cpu_wdata[0]),
            .cfg_dir_in(cpu_wdata[1]),
            .cfg_iso   (cpu_wdata[2]),
            .cnt_we    (hit_cnt),
            .cnt_wdata (cpu_wdata[CNT_W-1:0]),
            .tok_hit   (tok_valid && tok_ep == EP_W'(e)),
            .tok_kind  (tok_kind_e'(tok_kind)),
            .evt_sel   (cur_ep == EP_W'(e)),
            .dat_valid (dat_valid),
            .dat_odd   (dat_odd),
            .dat_len   (dat_len),
            .hsk_valid (hsk_valid),
            .hsk_kind  (hsk_kind_e'(hsk_kind)),
            .tmo_valid (tmo_valid),
            .armed     (ep_armed[e]),
            .dir_in    (ep_dir[e]),
            .iso       (ep_iso[e]),
            .count     (ep_count[e]),
            .status    (ep_stat[e]),
            .count_res (ep_res[e]),
            .done      (ep_done[e])
        );
    end

    ep_irq_bank #(.N_FLAG(N_FLAG)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  ({bus_rst, ep_done}),
        .en_we    (cpu_we && cpu_addr == ADDR_W'(IRQ_EN_A)),
        .en_wdata (cpu_wdata[N_FLAG-1:0]),
        .clr_we   (cpu_we && cpu_addr == ADDR_W'(IRQ_FLG_A)),
        .clr_wdata(cpu_wdata[N_FLAG-1:0]),
        .enables  (irq_en),
        .flags    (irq_flags)
    );

    always_comb begin
        cpu_rdata = '0;
        if (ep_space) begin
            unique case (a_reg)
                2'd0: cpu_rdata = DATA_W'({ep_iso[a_ep], ep_dir[a_ep], ep_armed[a_ep]});
                2'd1: cpu_rdata = DATA_W'(ep_count[a_ep]);
                2'd2: cpu_rdata = DATA_W'(ep_stat[a_ep]);
                2'd3: cpu_rdata = DATA_W'(ep_res[a_ep]);
                default: cpu_rdata = '0;
            endcase
        end else if (cpu_addr == ADDR_W'(IRQ_EN_A)) begin
            cpu_rdata = DATA_W'(irq_en);
        end else if (cpu_addr == ADDR_W'(IRQ_FLG_A)) begin
            cpu_rdata = DATA_W'(irq_flags);
        end
    end

    p_done_onehot_r4 : assert property (
        @(posedge clk) disable iff (!rst_n)
        $onehot0(ep_done)
    ) else $error("more than one endpoint finished at once");

    p_reset_flag_r12 : assert property (
        @(posedge clk) disable iff (!rst_n)
        (bus_rst && irq_en[N_EP]) |=> irq_flags[N_EP]
    ) else $error("bus reset flag missing");

endmodule

// File: tb/usb_ep_txn_tracker_tb.sv
module usb_ep_txn_tracker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tok_valid = 1'b0;
    logic [1:0]  tok_kind = 2'd0;
    logic [2:0]  tok_ep = 3'd0;
    logic        dat_valid = 1'b0;
    logic        dat_odd = 1'b0;
    logic [9:0]  dat_len = 10'd0;
    logic        hsk_valid = 1'b0;
    logic [1:0]  hsk_kind = 2'd0;
    logic        tmo_valid = 1'b0;
    logic        bus_rst = 1'b0;
    logic        cpu_we = 1'b0;
    logic [5:0]  cpu_addr = 6'd0;
    logic [15:0] cpu_wdata = 16'd0;
    logic [15:0] cpu_rdata;

    int    errors = 0;
    int    checks = 0;
    logic  mon_req = 1'b0;
    logic  finished = 1'b0;
    logic [15:0] q_exp [$];
    string       q_tag [$];

    always #5 clk = ~clk;

    usb_ep_txn_tracker u_dut (
        .clk(clk), .rst_n(rst_n),
        .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_ep(tok_ep),
        .dat_valid(dat_valid), .dat_odd(dat_odd), .dat_len(dat_len),
        .hsk_valid(hsk_valid), .hsk_kind(hsk_kind), .tmo_valid(tmo_valid),
        .bus_rst(bus_rst),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata)
    );

    localparam logic [5:0] A_EN  = 6'h20;
    localparam logic [5:0] A_FLG = 6'h21;
    function automatic logic [5:0] a_ctl(input int e); return 6'(e * 4);     endfunction
    function automatic logic [5:0] a_cnt(input int e); return 6'(e * 4 + 1); endfunction
    function automatic logic [5:0] a_st (input int e); return 6'(e * 4 + 2); endfunction
    function automatic logic [5:0] a_res(input int e); return 6'(e * 4 + 3); endfunction

    // monitor: compares the read port against the scoreboard queue
    always @(negedge clk) begin
        if (mon_req) begin
            logic [15:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if (cpu_rdata !== e) begin
                errors++;
                $display("FAIL %s: got 0x%04h expected 0x%04h", t, cpu_rdata, e);
            end
            mon_req = 1'b0;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        step();
        cpu_we = 1'b0;
    endtask

    task automatic expect_rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
        cpu_addr = a;
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        mon_req = 1'b1;
        @(negedge clk);
        #1;
    endtask

    task automatic tok(input logic [1:0] k, input int e);
        tok_valid = 1'b1; tok_kind = k; tok_ep = 3'(e);
        step();
        tok_valid = 1'b0;
    endtask

    task automatic dat(input logic odd, input int len);
        dat_valid = 1'b1; dat_odd = odd; dat_len = 10'(len);
        step();
        dat_valid = 1'b0;
    endtask

    task automatic hsk(input logic [1:0] k);
        hsk_valid = 1'b1; hsk_kind = k;
        step();
        hsk_valid = 1'b0;
    endtask

    task automatic tmo();
        tmo_valid = 1'b1;
        step();
        tmo_valid = 1'b0;
    endtask

    task automatic arm(input int e, input logic [15:0] ctl, input int cnt);
        wr(a_cnt(e), 16'(cnt));
        wr(a_ctl(e), ctl);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        expect_rd(a_ctl(0), 16'h0000, "R1 ctrl ep0");
        expect_rd(a_st(5),  16'h0000, "R1 status ep5");
        expect_rd(A_EN,     16'h0000, "R1 enables");
        expect_rd(A_FLG,    16'h0000, "R1 flags");

        wr(A_EN, 16'h01FF);
        expect_rd(A_EN, 16'h01FF, "R11 enable readback");

        // R2 arming, R4 OUT+ACK, R7 DATA1
        arm(1, 16'h0001, 64);
        expect_rd(a_ctl(1), 16'h0001, "R2 armed readback");
        tok(2'd0, 1);
        dat(1'b1, 40);
        hsk(2'd0);
        expect_rd(a_st(1),  16'h0009, "R4 R7 ack+seq status");
        expect_rd(a_res(1), 16'd24,   "R4 count result");
        expect_rd(a_ctl(1), 16'h0000, "R4 disarmed");
        expect_rd(A_FLG,    16'h0002, "R4 done flag");
        wr(A_FLG, 16'h0002);
        expect_rd(A_FLG,    16'h0000, "R11 w1c");

        // R2 disarm by write
        arm(7, 16'h0001, 4);
        wr(a_ctl(7), 16'h0000);
        expect_rd(a_ctl(7), 16'h0000, "R2 disarm");

        // R3 both exceptions
        arm(2, 16'h0003, 10);
        tok(2'd0, 2);
        expect_rd(a_st(2), 16'h0020, "R3 out exception");
        expect_rd(A_FLG,   16'h0004, "R3 out exc flag");
        wr(A_FLG, 16'h01FF);
        arm(3, 16'h0001, 10);
        tok(2'd1, 3);
        expect_rd(a_st(3), 16'h0010, "R3 in exception");
        expect_rd(A_FLG,   16'h0008, "R3 in exc flag");
        wr(A_FLG, 16'h01FF);

        // R9 NAK then R6 timeout on IN
        arm(4, 16'h0003, 8);
        tok(2'd1, 4);
        dat(1'b0, 8);
        hsk(2'd1);
        expect_rd(a_st(4),  16'h0000, "R9 status after NAK");
        expect_rd(a_ctl(4), 16'h0003, "R9 still armed");
        expect_rd(A_FLG,    16'h0000, "R9 no done");
        tok(2'd1, 4);
        dat(1'b0, 8);
        tmo();
        expect_rd(a_st(4),  16'h0004, "R6 timeout status");
        expect_rd(a_ctl(4), 16'h0002, "R6 disarmed");
        expect_rd(A_FLG,    16'h0010, "R6 done flag");
        wr(A_FLG, 16'h01FF);

        // R5 STALL instead of IN data
        arm(5, 16'h0003, 8);
        tok(2'd1, 5);
        hsk(2'd2);
        expect_rd(a_st(5), 16'h0002, "R5 stall status");
        expect_rd(A_FLG,   16'h0020, "R5 done flag");
        wr(A_FLG, 16'h01FF);

        // R8 isochronous OUT
        arm(6, 16'h0005, 1023);
        expect_rd(a_ctl(6), 16'h0005, "R2 iso readback");
        tok(2'd0, 6);
        dat(1'b0, 1000);
        expect_rd(a_st(6),  16'h0001, "R8 iso success");
        expect_rd(a_res(6), 16'd23,   "R8 iso count result");
        expect_rd(A_FLG,    16'h0040, "R8 done flag");
        wr(A_FLG, 16'h01FF);

        // R7 SETUP with DATA0
        arm(0, 16'h0001, 8);
        tok(2'd2, 0);
        dat(1'b0, 8);
        hsk(2'd0);
        expect_rd(a_st(0),  16'h0041, "R7 setup status");
        expect_rd(a_res(0), 16'd0,    "R7 setup count result");
        wr(A_FLG, 16'h01FF);

        // R10 unarmed endpoint ignores traffic
        tok(2'd0, 7);
        dat(1'b1, 3);
        hsk(2'd0);
        expect_rd(a_st(7),  16'h0000, "R10 unarmed status");
        expect_rd(a_res(7), 16'h0000, "R10 unarmed result");
        expect_rd(A_FLG,    16'h0000, "R10 no flag");

        // R11 masked endpoint flag
        wr(A_EN, 16'h0100);
        arm(1, 16'h0001, 4);
        tok(2'd0, 1);
        dat(1'b0, 4);
        hsk(2'd0);
        expect_rd(a_st(1), 16'h0001, "R11 status while masked");
        expect_rd(A_FLG,   16'h0000, "R11 masked flag");

        // R11 set beats clear in the same cycle
        wr(A_EN, 16'h01FF);
        arm(1, 16'h0001, 4);
        tok(2'd0, 1);
        dat(1'b0, 2);
        cpu_addr = A_FLG; cpu_wdata = 16'h0002; cpu_we = 1'b1;
        hsk_valid = 1'b1; hsk_kind = 2'd0;
        step();
        cpu_we = 1'b0; hsk_valid = 1'b0;
        expect_rd(A_FLG,    16'h0002, "R11 set wins over clear");
        expect_rd(a_res(1), 16'd2,    "R4 partial count result");

        // R12 bus reset mid-transaction
        arm(2, 16'h0003, 16);
        tok(2'd1, 2);
        bus_rst = 1'b1;
        step();
        bus_rst = 1'b0;
        expect_rd(A_FLG,    16'h0102, "R12 reset flag");
        expect_rd(a_ctl(2), 16'h0002, "R12 disarmed");
        expect_rd(a_st(1),  16'h0000, "R12 status cleared ep1");
        expect_rd(a_st(0),  16'h0000, "R12 status cleared ep0");

        step();
        finish_run();
    end

endmodule